// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block watches fifteen interrupt request lines, numbered 1 to 15, on a shared interrupt bus and latches every request into one pending register that all processors share. A request is caught even when the line is high for a single clock, and it remains recorded until software clears it or a processor acknowledges it. Line 0 of the bus is never watched.

Each line belongs to a high level or a low level, chosen in a level register. For every processor, the block takes the pending requests, adds that processor's own force bits, and keeps only the lines enabled in that processor's mask. It then presents one 4-bit interrupt number to the processor. A high-level candidate always wins. When there is none, the low-level candidates compete. Within a level the larger line number wins, and the number 0 means that nothing is requested.

A processor signals that it has taken an interrupt by acknowledging that number. If the processor has its own force bit for that line, the acknowledge clears the force bit. Otherwise it clears the shared pending bit. Software programs the level, mask and force registers and clears pending bits through a simple write port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Reset clears the level, mask, force and pending registers, so every interrupt number output reads 0. A line that is high while reset is asserted leaves nothing pending.
- R2: A line k in 1..15 that is high for one clock sets pending bit k. The bit stays set after the line drops until it is cleared.
- R3: Line 0 never becomes pending and never produces a request, whatever the masks and levels hold.
- R4: Within one level, a processor's output is the highest-numbered line in its candidate set. Line 15 ranks highest and line 1 lowest.
- R5: A line whose level bit is 1 outranks every line whose level bit is 0, whatever the line numbers.
- R6: For processor c, the candidate set is (pending OR force[c]) AND mask[c]. Each processor has its own mask and force register, so one processor's force bits do not reach another processor.
- R7: An acknowledge from processor c carrying number k clears force[c] bit k if that bit is set. Otherwise it clears pending bit k. An acknowledge of 0 does nothing.
- R8: A write with regSel = 3 clears every pending bit whose regData bit is 1 and leaves the other pending bits unchanged. regSel = 0 writes the level register (bit k = 1 places line k on the high level). regSel = 1 writes mask[regCpu] (bit k = 1 enables line k). regSel = 2 writes force[regCpu].
- R9: If a request on line k arrives in the same clock as a software clear or an acknowledge of pending bit k, the bit stays set.
- R10: A processor whose candidate set is empty sees interrupt number 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 16 | Interrupt bus; bits 15..1 are request lines, bit 0 is ignored |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Write target: 0 level, 1 mask, 2 force, 3 pending clear |
| regCpu | input | CPU_W | Processor index for mask and force writes |
| regData | input | 16 | Write data, one bit per line |
| ackValid | input | NCPU | Acknowledge strobe, one per processor |
| ackNum | input | 4*NCPU | Acknowledged interrupt number, 4 bits per processor |
| irqNum | output | 4*NCPU | Presented interrupt number, 4 bits per processor; 0 = none |

## Verification
The acknowledge assertion expects an acknowledged number to come from the processor's own mask and force state, and it leaves out the clock in which a fresh request on the same line sets the bit again. The bench respects this by acknowledging only numbers that the processor is showing, and by keeping request pulses and acknowledges on different lines except in the deliberate collision test. The assertions do not depend on how long a request stays high. The stimulus uses single-clock pulses throughout, which is the normal way peripherals signal.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned LINE_W = 16;
  localparam int unsigned ID_W = 4;
  localparam logic [LINE_W-1:0] LIVE_LINES = 16'hFFFE;

  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_FORCE = 2'd2,
    SEL_PCLR  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              levelWe;
    logic [LINE_W-1:0] wrData;
    logic [LINE_W-1:0] pendClr;
  } strobe_t;

  function automatic logic [ID_W-1:0] topBit(input logic [LINE_W-1:0] v);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = 1; i < LINE_W; i++) begin
      if (v[i]) r = ID_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NCPU = 2,
  parameter int unsigned CPU_W = 1
) (
  input  logic                         regWe,
  input  logic [1:0]                   regSel,
  input  logic [CPU_W-1:0]             regCpu,
  input  logic [LINE_W-1:0]            regData,
  input  logic [NCPU-1:0]              ackValid,
  input  logic [NCPU*ID_W-1:0]         ackNum,
  input  logic [NCPU-1:0][LINE_W-1:0]  forceQ,
  output strobe_t                      strb,
  output logic [NCPU-1:0]              maskWe,
  output logic [NCPU-1:0]              forceWe,
  output logic [NCPU-1:0][LINE_W-1:0]  forceClr
);
  logic [LINE_W-1:0] ackPendClr;

  always_comb begin
    ackPendClr = '0;
    maskWe = '0;
    forceWe = '0;
    forceClr = '0;
    for (int c = 0; c < NCPU; c++) begin
      logic [ID_W-1:0] id;
      logic [LINE_W-1:0] hit;
      id = ackNum[c*ID_W +: ID_W];
      hit = LINE_W'(1) << id;
      hit = hit & LIVE_LINES;
      if (ackValid[c]) begin
        if (|(forceQ[c] & hit)) forceClr[c] = hit;
        else ackPendClr = ackPendClr | hit;
      end
      if (regWe && regCpu == CPU_W'(c)) begin
        maskWe[c]  = (regSel == SEL_MASK);
        forceWe[c] = (regSel == SEL_FORCE);
      end
    end
    strb.levelWe = regWe && (regSel == SEL_LEVEL);
    strb.wrData  = regData & LIVE_LINES;
    strb.pendClr = ackPendClr | ((regWe && regSel == SEL_PCLR) ? regData : '0);
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int unsigned NCPU = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [LINE_W-1:0]            irqIn,
  input  strobe_t                      strb,
  input  logic [NCPU-1:0]              maskWe,
  input  logic [NCPU-1:0]              forceWe,
  input  logic [NCPU-1:0][LINE_W-1:0]  forceClr,
  output logic [LINE_W-1:0]            pendQ,
  output logic [LINE_W-1:0]            levelQ,
  output logic [NCPU-1:0][LINE_W-1:0]  maskQ,
  output logic [NCPU-1:0][LINE_W-1:0]  forceQ
);
  logic [LINE_W-1:0] liveIrq;
  assign liveIrq = irqIn & LIVE_LINES;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      levelQ <= '0;
    end else begin
      pendQ <= (pendQ & ~strb.pendClr) | liveIrq;
      if (strb.levelWe) levelQ <= strb.wrData;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ[c]  <= '0;
        forceQ[c] <= '0;
      end else begin
        if (maskWe[c]) maskQ[c] <= strb.wrData;
        if (forceWe[c]) forceQ[c] <= strb.wrData;
        else forceQ[c] <= forceQ[c] & ~forceClr[c];
      end
    end
  end

  // R2 / R9: every live request is pending one clock later
  p_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|liveIrq) |=> ((pendQ & $past(liveIrq)) == $past(liveIrq)));

  // R2: bits not being cleared stay set
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|(pendQ & ~strb.pendClr)) |=>
      ((pendQ & $past(pendQ & ~strb.pendClr)) == $past(pendQ & ~strb.pendClr)));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] pendQ,
  input  logic [LINE_W-1:0] levelQ,
  input  logic [LINE_W-1:0] maskQ,
  input  logic [LINE_W-1:0] forceQ,
  output logic [ID_W-1:0]   outId
);
  logic [LINE_W-1:0] cand;
  logic [LINE_W-1:0] hiSet;
  logic [LINE_W-1:0] loSet;

  always_comb begin
    cand  = (pendQ | forceQ) & maskQ & LIVE_LINES;
    hiSet = cand & levelQ;
    loSet = cand & ~levelQ;
    outId = (|hiSet) ? topBit(hiSet) : topBit(loSet);
  end

  // R6: a presented number is always a live candidate
  p_out_candidate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outId != '0) |-> (((pendQ | forceQ) & maskQ) >> outId) != '0);

  // R10: nothing to offer gives number 0
  p_none_r10: assert property (@(posedge clk) disable iff (!rstN)
    (((pendQ | forceQ) & maskQ & LIVE_LINES) == '0) |-> (outId == '0));

  // R5: a high-level candidate forces a high-level answer
  p_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|((pendQ | forceQ) & maskQ & levelQ & LIVE_LINES)) |-> levelQ[outId]);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NCPU = 2,
  localparam int unsigned CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [15:0]          irqIn,
  input  logic                 regWe,
  input  logic [1:0]           regSel,
  input  logic [CPU_W-1:0]     regCpu,
  input  logic [15:0]          regData,
  input  logic [NCPU-1:0]      ackValid,
  input  logic [NCPU*4-1:0]    ackNum,
  output logic [NCPU*4-1:0]    irqNum
);
  strobe_t                     strb;
  logic [NCPU-1:0]             maskWe;
  logic [NCPU-1:0]             forceWe;
  logic [NCPU-1:0][LINE_W-1:0] forceClr;
  logic [LINE_W-1:0]           pendQ;
  logic [LINE_W-1:0]           levelQ;
  logic [NCPU-1:0][LINE_W-1:0] maskQ;
  logic [NCPU-1:0][LINE_W-1:0] forceQ;

  irqc_ctrl #(.NCPU(NCPU), .CPU_W(CPU_W)) u_ctrl (
    .regWe(regWe), .regSel(regSel), .regCpu(regCpu), .regData(regData),
    .ackValid(ackValid), .ackNum(ackNum), .forceQ(forceQ),
    .strb(strb), .maskWe(maskWe), .forceWe(forceWe), .forceClr(forceClr)
  );

  irqc_datapath #(.NCPU(NCPU)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strb(strb),
    .maskWe(maskWe), .forceWe(forceWe), .forceClr(forceClr),
    .pendQ(pendQ), .levelQ(levelQ), .maskQ(maskQ), .forceQ(forceQ)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_prio
    logic [ID_W-1:0] ackId;
    assign ackId = ackNum[c*ID_W +: ID_W];

    irqc_prio u_prio (
      .clk(clk), .rstN(rstN), .pendQ(pendQ), .levelQ(levelQ),
      .maskQ(maskQ[c]), .forceQ(forceQ[c]), .outId(irqNum[c*ID_W +: ID_W])
    );

    // R7: acknowledge without own force bit and without a new request drops pending
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
      (ackValid[c] && !forceQ[c][ackId] && !irqIn[ackId]) |=> !pendQ[$past(ackId)]);
  end
endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  localparam int NCPU = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] irqIn;
  logic        regWe;
  logic [1:0]  regSel;
  logic [0:0]  regCpu;
  logic [15:0] regData;
  logic [1:0]  ackValid;
  logic [7:0]  ackNum;
  logic [7:0]  irqNum;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.NCPU(NCPU)) uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWe(regWe), .regSel(regSel),
    .regCpu(regCpu), .regData(regData), .ackValid(ackValid), .ackNum(ackNum),
    .irqNum(irqNum)
  );

  // {level, mask0, mask1, pulse, expect0, expect1}
  localparam int NVEC = 7;
  localparam logic [71:0] VEC [NVEC] = '{
    {16'h0000, 16'hFFFF, 16'hFFFF, 16'h0006, 4'd2,  4'd2 },  // R4
    {16'h0002, 16'hFFFF, 16'hFFFF, 16'h8002, 4'd1,  4'd1 },  // R5
    {16'h0000, 16'h00FE, 16'hFF00, 16'h8010, 4'd4,  4'd15},  // R6
    {16'h0100, 16'hFFFF, 16'hFEFF, 16'h0180, 4'd8,  4'd7 },  // R5 R6
    {16'h0000, 16'hFFFF, 16'hFFFF, 16'h0001, 4'd0,  4'd0 },  // R3
    {16'hFFFE, 16'h0000, 16'h0A00, 16'h0E00, 4'd0,  4'd11},  // R10 R4
    {16'h4000, 16'hFFFF, 16'hFFFF, 16'hC000, 4'd14, 4'd14}   // R5
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic cpu, input logic [15:0] data);
    regWe = 1'b1; regSel = sel; regCpu = cpu; regData = data;
    step();
    regWe = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] lines);
    irqIn = lines;
    step();
    irqIn = '0;
  endtask

  task automatic ack(input int cpu, input logic [3:0] num);
    ackValid[cpu] = 1'b1;
    ackNum[cpu*4 +: 4] = num;
    step();
    ackValid = '0;
    ackNum = '0;
  endtask

  task automatic check(input string req, input int cpu, input logic [3:0] exp);
    logic [3:0] got;
    got = irqNum[cpu*4 +: 4];
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cpu%0d: irqNum=%0d expected %0d", req, cpu, got, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; irqIn = 16'h8421; regWe = 1'b0; regSel = '0; regCpu = '0;
    regData = '0; ackValid = '0; ackNum = '0;
    repeat (3) step();
    rstN = 1'b1;
    irqIn = '0;
    check("R1", 0, 4'd0);
    check("R1", 1, 4'd0);
    regWrite(2'd1, 1'b0, 16'hFFFF);
    regWrite(2'd1, 1'b1, 16'hFFFF);
    check("R1", 0, 4'd0);   // nothing captured under reset
    check("R1", 1, 4'd0);

    for (int i = 0; i < NVEC; i++) begin
      regWrite(2'd3, 1'b0, 16'hFFFF);
      regWrite(2'd0, 1'b0, VEC[i][71:56]);
      regWrite(2'd1, 1'b0, VEC[i][55:40]);
      regWrite(2'd1, 1'b1, VEC[i][39:24]);
      pulse(VEC[i][23:8]);
      step();
      check("R4/R5/R6 table", 0, VEC[i][7:4]);
      check("R4/R5/R6 table", 1, VEC[i][3:0]);
    end

    // R2: sticky after the line drops
    regWrite(2'd3, 1'b0, 16'hFFFF);
    regWrite(2'd0, 1'b0, 16'h0000);
    regWrite(2'd1, 1'b0, 16'hFFFF);
    regWrite(2'd1, 1'b1, 16'hFFFF);
    pulse(16'h0030);
    repeat (3) step();
    check("R2", 0, 4'd5);
    // R8: software clear of selected bits
    regWrite(2'd3, 1'b0, 16'h0020);
    check("R8", 0, 4'd4);
    check("R8", 1, 4'd4);
    regWrite(2'd3, 1'b0, 16'h0010);
    check("R8", 0, 4'd0);
    check("R10", 1, 4'd0);

    // R7: acknowledge clears pending when no force bit
    pulse(16'h0040);
    check("R7", 1, 4'd6);
    ack(0, 4'd6);
    check("R7", 0, 4'd0);
    check("R7", 1, 4'd0);
    // R6: force reaches only its own processor
    regWrite(2'd2, 1'b1, 16'h0200);
    check("R6", 1, 4'd9);
    check("R6", 0, 4'd0);
    pulse(16'h0200);
    check("R6", 0, 4'd9);
    // R7: acknowledge clears the force bit first, pending remains
    ack(1, 4'd9);
    check("R7", 1, 4'd9);
    check("R7", 0, 4'd9);
    ack(1, 4'd9);
    check("R7", 1, 4'd0);
    check("R7", 0, 4'd0);

    // R9: request wins over simultaneous software clear
    pulse(16'h0008);
    irqIn = 16'h0008;
    regWrite(2'd3, 1'b0, 16'h0008);
    irqIn = '0;
    check("R9", 0, 4'd3);
    // R9: request wins over simultaneous acknowledge
    irqIn = 16'h0008;
    ack(0, 4'd3);
    irqIn = '0;
    check("R9", 0, 4'd3);
    check("R9", 1, 4'd3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule